// File: doc/BRIEF.md
# Clock Root Control Register File

This block holds the software-visible control state of a single clock root. A host reaches five 32-bit registers over a plain address, write-data, write-enable and read-data bus. Writes to the configuration registers fill a staging (shadow) copy of the settings: source select, predivider, counter mode, hardware clock-control enable, and the three counter values. The clock mux and the divider use only the active copy. That copy changes only when software sets the self-clearing update bit.

When the update bit is set, a fixed count of cycles passes. The whole shadow set is then copied to the active outputs on a single clock edge, and the update bit clears itself so that software can poll for completion. Each configuration register has its own dirty flag. The flag marks a change that has not yet been applied. A force-enable bit drives a request to the root, and a read-only status bit reports whether the root is stopped.

The three counter registers use an inverted encoding that the downstream divider decodes. The M register holds m. The N register holds the bitwise inverse of (n - m). The D register holds the bitwise inverse of n. Each is kept to `MN_W` bits. This block stores them and passes them on unchanged.

Top module: `clk_root_cfg_regs`

## Requirements
- R1: After reset every stored field is zero and no update is pending. The active outputs and the force request are all zero, and a read of the command register (byte address 0x00) returns only the root-off status in bit 31.
- R2: The configuration register (byte address 0x04) holds the predivider in bits PD_W-1:0, the source select in bits 10:8, the mode in bits 13:12 and the hardware clock-control enable in bit 20. All its other bits read as zero.
- R3: The M (0x08), N (0x0C) and D (0x10) registers store and return only their low MN_W bits. Their upper bits read as zero.
- R4: A read at any byte address other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns zero. A write there changes no register.
- R5: Writes to the configuration and counter registers leave every active output unchanged until an update is applied.
- R6: Writing 1 to command bit 0 starts an update, and bit 0 then reads 1. Exactly UPD_LAT cycles after the write edge, all shadow fields are copied to the active outputs on one edge and bit 0 reads 0 again.
- R7: Command bits 4, 5, 6 and 7 are dirty flags for the configuration, N, M and D registers. Each flag sets when its register is written and clears when an update is applied.
- R8: If a register write lands on the same edge as an update apply, the shadow register takes the new value. The active output takes the shadow value from before that write, and that register's dirty flag remains set.
- R9: Command bit 1 is a read/write force-enable that drives `force_en_o`.
- R10: Command bit 31 reads 1 only when `root_active_i` is low and force-enable is clear; otherwise it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| root_active_i | input | 1 | High while the divider reports the root clock running |
| force_en_o | output | 1 | Force-enable request to the root |
| act_prediv | output | PD_W | Active predivider value |
| act_src_sel | output | 3 | Active mux source select |
| act_mode | output | 2 | Active counter mode (2 = dual-edge M/N) |
| act_hw_ctl | output | 1 | Active hardware clock-control enable |
| act_m | output | MN_W | Active M register contents |
| act_n | output | MN_W | Active N register contents (inverted encoding) |
| act_d | output | MN_W | Active D register contents (inverted encoding) |

## Verification
The functions that can fall on the same edge are a software register write and the update apply. The apply copies shadow to active and clears the dirty flags, while the write loads the shadow and sets its dirty flag. The bench counts cycles from the update command and times an M write to land exactly on the apply edge. It then checks three things: the active M holds the value staged before the collision, the shadow reads the new value, and only the M dirty flag remains set. A second update must then carry the new value through to the active output.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CMD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_M   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_N   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_D   = 5'h10;

  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_FORCE_BIT = 1;
  localparam int CMD_DIRTY_LSB = 4;
  localparam int CMD_OFF_BIT   = 31;

  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam int CFG_HWC_BIT  = 20;

  localparam int NUM_DIRTY = 4;
  localparam int NUM_CNT   = 3;

  // dirty/write-enable index: 0 cfg, 1 N, 2 M, 3 D
  localparam int WI_CFG = 0;

  typedef struct packed {
    logic       hwc;
    logic [1:0] mode;
    logic [2:0] src;
  } crc_sel_t;
endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_q_n = stage[1];
endmodule

// File: rtl/crc_upd_ctl.sv
module crc_upd_ctl #(
  parameter int UPD_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pend,
  output logic apply
);
  localparam int CW = $clog2(UPD_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(UPD_LAT - 1);

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    apply  = pend_q && (cnt_q == LAST);
    pend_d = pend_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!pend_q && start) begin
      pend_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (apply) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pend = pend_q;

  // R6
  upd_clears_after_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !pend_q);
  // R6
  upd_holds_until_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !apply) |=> pend_q);
endmodule

// File: rtl/crc_shadow.sv
module crc_shadow
  import crc_pkg::*;
#(
  parameter int PD_W = 5,
  parameter int MN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_DIRTY-1:0] wr_en,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 apply,
  output logic [PD_W-1:0]      sh_prediv,
  output crc_sel_t             sh_sel,
  output logic [MN_W-1:0]      sh_cnt [NUM_CNT],
  output logic [PD_W-1:0]      act_prediv,
  output crc_sel_t             act_sel,
  output logic [MN_W-1:0]      act_cnt [NUM_CNT],
  output logic [NUM_DIRTY-1:0] dirty
);
  logic [PD_W-1:0]      pd_q, pd_d;
  crc_sel_t             sel_q, sel_d;
  logic [PD_W-1:0]      apd_q;
  crc_sel_t             asel_q;
  logic [NUM_DIRTY-1:0] dirty_q, dirty_d;

  always_comb begin
    pd_d  = wdata[PD_W-1:0];
    sel_d = '{hwc:  wdata[CFG_HWC_BIT],
              mode: wdata[CFG_MODE_LSB +: 2],
              src:  wdata[CFG_SRC_LSB +: 3]};
    // a write on the apply edge keeps its flag: it was not applied
    dirty_d = (apply ? '0 : dirty_q) | wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q    <= '0;
      sel_q   <= '0;
      apd_q   <= '0;
      asel_q  <= '0;
      dirty_q <= '0;
    end else begin
      if (wr_en[WI_CFG]) begin
        pd_q  <= pd_d;
        sel_q <= sel_d;
      end
      if (apply) begin
        apd_q  <= pd_q;
        asel_q <= sel_q;
      end
      dirty_q <= dirty_d;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [MN_W-1:0] sh_q, ac_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
        ac_q <= '0;
      end else begin
        if (wr_en[g+1]) sh_q <= wdata[MN_W-1:0];
        if (apply)      ac_q <= sh_q;
      end
    end
    assign sh_cnt[g]  = sh_q;
    assign act_cnt[g] = ac_q;
  end

  assign sh_prediv  = pd_q;
  assign sh_sel     = sel_q;
  assign act_prediv = apd_q;
  assign act_sel    = asel_q;
  assign dirty      = dirty_q;

  // R5
  act_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(apd_q) && $stable(asel_q)));
  // R7
  dirty_clear_on_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && (wr_en == '0)) |=> (dirty_q == '0));
  // R8
  dirty_wins_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && wr_en[WI_CFG]) |=> dirty_q[WI_CFG]);
endmodule

// File: rtl/clk_root_cfg_regs.sv
module clk_root_cfg_regs
  import crc_pkg::*;
#(
  parameter int PD_W    = 5,
  parameter int MN_W    = 8,
  parameter int UPD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              root_active_i,
  output logic              force_en_o,
  output logic [PD_W-1:0]   act_prediv,
  output logic [2:0]        act_src_sel,
  output logic [1:0]        act_mode,
  output logic              act_hw_ctl,
  output logic [MN_W-1:0]   act_m,
  output logic [MN_W-1:0]   act_n,
  output logic [MN_W-1:0]   act_d
);
  logic                 rst_q_n;
  logic                 is_cmd, upd_start, upd_pend, upd_apply;
  logic [NUM_DIRTY-1:0] wr_en, dirty;
  logic                 force_q;
  logic                 root_off;
  logic [PD_W-1:0]      sh_prediv;
  crc_sel_t             sh_sel, act_sel;
  logic [MN_W-1:0]      sh_cnt  [NUM_CNT];
  logic [MN_W-1:0]      act_cnt [NUM_CNT];

  crc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  always_comb begin
    is_cmd    = bus_wr && (bus_addr == OFS_CMD);
    upd_start = is_cmd && bus_wdata[CMD_UPD_BIT];
    wr_en     = '0;
    if (bus_wr) begin
      wr_en[0] = (bus_addr == OFS_CFG);
      wr_en[1] = (bus_addr == OFS_N);
      wr_en[2] = (bus_addr == OFS_M);
      wr_en[3] = (bus_addr == OFS_D);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    force_q <= 1'b0;
    else if (is_cmd) force_q <= bus_wdata[CMD_FORCE_BIT];
  end

  crc_upd_ctl #(.UPD_LAT(UPD_LAT)) u_upd (
    .clk(clk), .rst_n(rst_q_n), .start(upd_start),
    .pend(upd_pend), .apply(upd_apply)
  );

  crc_shadow #(.PD_W(PD_W), .MN_W(MN_W)) u_shadow (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wdata(bus_wdata),
    .apply(upd_apply), .sh_prediv(sh_prediv), .sh_sel(sh_sel),
    .sh_cnt(sh_cnt), .act_prediv(act_prediv), .act_sel(act_sel),
    .act_cnt(act_cnt), .dirty(dirty)
  );

  assign root_off = !root_active_i && !force_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CMD: begin
        bus_rdata[CMD_UPD_BIT]                  = upd_pend;
        bus_rdata[CMD_FORCE_BIT]                = force_q;
        bus_rdata[CMD_DIRTY_LSB +: NUM_DIRTY]   = dirty;
        bus_rdata[CMD_OFF_BIT]                  = root_off;
      end
      OFS_CFG: begin
        bus_rdata[PD_W-1:0]          = sh_prediv;
        bus_rdata[CFG_SRC_LSB +: 3]  = sh_sel.src;
        bus_rdata[CFG_MODE_LSB +: 2] = sh_sel.mode;
        bus_rdata[CFG_HWC_BIT]       = sh_sel.hwc;
      end
      OFS_N:   bus_rdata[MN_W-1:0] = sh_cnt[0];
      OFS_M:   bus_rdata[MN_W-1:0] = sh_cnt[1];
      OFS_D:   bus_rdata[MN_W-1:0] = sh_cnt[2];
      default: bus_rdata = '0;
    endcase
  end

  assign force_en_o  = force_q;
  assign act_src_sel = act_sel.src;
  assign act_mode    = act_sel.mode;
  assign act_hw_ctl  = act_sel.hwc;
  assign act_n       = act_cnt[0];
  assign act_m       = act_cnt[1];
  assign act_d       = act_cnt[2];

  // R10
  force_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((bus_addr == OFS_CMD) && force_en_o) |-> !bus_rdata[CMD_OFF_BIT]);
  // R2
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == OFS_CFG) |-> (bus_rdata[31:21] == 11'd0));
  // R7
  dirty_sets_on_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && (bus_addr == OFS_M)) |=> dirty[2]);
endmodule

// File: tb/tb_clk_root_cfg_regs.sv
module tb_clk_root_cfg_regs;
  localparam int PD_W = 5;
  localparam int MN_W = 8;
  localparam int LAT  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            root_active_i = 1'b0;
  logic            force_en_o;
  logic [PD_W-1:0] act_prediv;
  logic [2:0]      act_src_sel;
  logic [1:0]      act_mode;
  logic            act_hw_ctl;
  logic [MN_W-1:0] act_m, act_n, act_d;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_root_cfg_regs #(.PD_W(PD_W), .MN_W(MN_W), .UPD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .root_active_i(root_active_i),
    .force_en_o(force_en_o), .act_prediv(act_prediv), .act_src_sel(act_src_sel),
    .act_mode(act_mode), .act_hw_ctl(act_hw_ctl), .act_m(act_m),
    .act_n(act_n), .act_d(act_d)
  );

  // {is_write, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'h04, 32'hFFFF_FFFF, 32'h0},          // R2 all ones to CFG
    {1'b0, 5'h04, 32'h0,         32'h0010_371F},  // R2 fields only
    {1'b0, 5'h00, 32'h0,         32'h8000_0010},  // R7 CFG dirty
    {1'b1, 5'h08, 32'hFFFF_FF03, 32'h0},          // R3 M
    {1'b0, 5'h08, 32'h0,         32'h0000_0003},
    {1'b1, 5'h0C, 32'h1234_56FA, 32'h0},          // R3 N = ~(8-3)
    {1'b0, 5'h0C, 32'h0,         32'h0000_00FA},
    {1'b1, 5'h10, 32'hFFFF_FFF7, 32'h0},          // R3 D = ~8
    {1'b0, 5'h10, 32'h0,         32'h0000_00F7},
    {1'b0, 5'h00, 32'h0,         32'h8000_00F0},  // R7 all dirty
    {1'b1, 5'h14, 32'hFFFF_FFFF, 32'h0},          // R4 unmapped write
    {1'b0, 5'h14, 32'h0,         32'h0},          // R4 unmapped read
    {1'b0, 5'h06, 32'h0,         32'h0},          // R4 misaligned read
    {1'b0, 5'h04, 32'h0,         32'h0010_371F},  // R4 CFG untouched
    {1'b1, 5'h04, 32'h0000_2205, 32'h0},          // R2 src 2 mode 2 div 5
    {1'b0, 5'h04, 32'h0,         32'h0000_2205}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_act(input string tag, input logic [31:0] pd, input logic [31:0] src,
                         input logic [31:0] md, input logic [31:0] m,
                         input logic [31:0] n, input logic [31:0] d);
    chk({tag, " prediv"}, 32'(act_prediv), pd);
    chk({tag, " src"},    32'(act_src_sel), src);
    chk({tag, " mode"},   32'(act_mode), md);
    chk({tag, " hwctl"},  32'(act_hw_ctl), 32'd0);
    chk({tag, " m"},      32'(act_m), m);
    chk({tag, " n"},      32'(act_n), n);
    chk({tag, " d"},      32'(act_d), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(5'h00, 32'h8000_0000, "R1 cmd after reset");
    rd(5'h04, 32'h0, "R1 cfg after reset");
    chk_act("R1", 0, 0, 0, 0, 0, 0);
    chk("R1 force", 32'(force_en_o), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      else            rd(VEC[i][68:64], VEC[i][31:0], $sformatf("R2/R3/R4/R7 vec %0d", i));
    end
    // R5 nothing applied yet
    chk_act("R5 before update", 0, 0, 0, 0, 0, 0);

    // R6 update timing
    wr(5'h00, 32'h1);
    rd(5'h00, 32'h8000_00F1, "R6 pending after write");
    chk_act("R5 edge 0", 0, 0, 0, 0, 0, 0);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      rd(5'h00, 32'h8000_00F1, "R6 still pending");
      chk_act("R5 waiting", 0, 0, 0, 0, 0, 0);
    end
    @(negedge clk);
    rd(5'h00, 32'h8000_0000, "R6/R7 update done dirty clear");
    chk_act("R6 applied", 5, 2, 2, 8'h03, 8'hFA, 8'hF7);

    // R8 collision of write and apply
    wr(5'h08, 32'h11);
    wr(5'h00, 32'h1);
    @(negedge clk);
    @(negedge clk);
    wr(5'h08, 32'h22);  // lands on the apply edge
    chk("R8 active m from old shadow", 32'(act_m), 32'h11);
    rd(5'h08, 32'h22, "R8 shadow m new");
    rd(5'h00, 32'h8000_0040, "R8 m dirty kept");
    wr(5'h00, 32'h1);
    repeat (LAT) @(negedge clk);
    chk("R8 second update", 32'(act_m), 32'h22);
    rd(5'h00, 32'h8000_0000, "R8 dirty cleared");

    // R9/R10 force and root-off
    wr(5'h00, 32'h2);
    chk("R9 force out", 32'(force_en_o), 32'd1);
    rd(5'h00, 32'h0000_0002, "R10 forced not off");
    wr(5'h00, 32'h0);
    chk("R9 force cleared", 32'(force_en_o), 32'd0);
    rd(5'h00, 32'h8000_0000, "R10 off when idle");
    root_active_i = 1'b1;
    rd(5'h00, 32'h0000_0000, "R10 running");
    root_active_i = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule